// File: doc/BRIEF.md
# Array Floating-Point Divider

This unit divides one floating-point operand by another without any reciprocal estimate or iteration loop. The operands use a sign bit, an 8-bit biased exponent (bias 127) and a mantissa of `MAN_W` stored bits with an implied leading one. The significand quotient comes from a cascade of identical subtract-and-select rows. Each row makes one quotient bit, most significant first, the way long division is done on paper. The result sign and exponent are formed by separate logic beside the array. A final stage normalizes the quotient, drops the bits below the mantissa, and packs sign, exponent and mantissa into the result word.

An operand pair is presented with `in_valid`. The packed quotient appears on `out_q` one clock later, together with `out_valid`, so the fixed latency is one cycle. A stored exponent field of zero marks an operand as zero, and its mantissa field is then disregarded. Exponent 255 on an input is handled as an ordinary number. No rounding is applied.

Top module: `fpdiv_sa_top`

## Requirements
- R1: The result sign (bit `MAN_W+8`) is the XOR of the sign bits of `in_a` and `in_b`, in every case including zero, overflow and divide-by-zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_q` carries that pair's result in the same cycle. Reset clears `out_valid` and `out_q` to zero.
- R3: For nonzero operands with significands `ma` and `mb` (1 followed by the mantissa field), the mantissa field of the result is the truncated quotient. When `ma >= mb` it is `floor(ma*2^MAN_W/mb) - 2^MAN_W`. Otherwise it is `floor(ma*2^(MAN_W+1)/mb) - 2^MAN_W`.
- R4: For nonzero operands, the result exponent is `ea - eb + 127` when `ma >= mb` and `ea - eb + 126` otherwise, whenever that value lies in 1..254.
- R5: When the exponent from R4 is 0 or below, the result is a signed zero: exponent and mantissa fields are all zeros.
- R6: When the exponent from R4 is 255 or above, the result exponent field is 255 and the mantissa field is zero.
- R7: A dividend with exponent field 0, divided by a divisor with a nonzero exponent field, gives a signed zero.
- R8: A divisor with exponent field 0 gives exponent field 255 and mantissa zero, whatever the dividend is, including a zero dividend.
- R9: Dividing any nonzero operand by itself gives exponent 127 and mantissa zero.
- R10: In a cycle with `in_valid` low, `in_a` and `in_b` are ignored: in the following cycle `out_valid` is low and `out_q` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | MAN_W+9 | Dividend: sign, exponent, mantissa |
| in_b | input | MAN_W+9 | Divisor: sign, exponent, mantissa |
| out_valid | output | 1 | Result present this cycle |
| out_q | output | MAN_W+9 | Packed quotient |

## Verification
The bound checker watches, on every cycle, the one-cycle handshake, the sign XOR, the hold of `out_q` across idle cycles, and the fixed encodings for a zero dividend, a zero divisor and self-division. Only the bench's scenarios can show the truncated significand bits and the two exponent offsets, which depend on whether the dividend's significand is below the divisor's. The same holds for the boundary where the exponent crosses into underflow or overflow. Directed pairs place values on both sides of each boundary, and a long random run with idle gaps and junk operands covers the rest.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
    localparam int EXP_W = 8;
    localparam int BIAS  = 127;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
endpackage

// File: rtl/fpdiv_pu_row.sv
module fpdiv_pu_row #(
    parameter int MAN_W = 7
) (
    input  logic [MAN_W:0] rem_in,
    input  logic           dbit,
    input  logic [MAN_W:0] divisor,
    output logic           qbit,
    output logic [MAN_W:0] rem_out
);
    // Partial remainder shifted one place with the next dividend bit brought down.
    logic [MAN_W+1:0] shifted;
    logic [MAN_W+1:0] sub;

    always_comb begin
        shifted = {rem_in, dbit};
        sub     = shifted - {1'b0, divisor};
        // shifted < 2*divisor, so the top bit of sub is the borrow out.
        qbit    = ~sub[MAN_W+1];
        rem_out = qbit ? sub[MAN_W:0] : shifted[MAN_W:0];
    end
endmodule

// File: rtl/fpdiv_mant_array.sv
module fpdiv_mant_array #(
    parameter int MAN_W = 7
) (
    input  logic [MAN_W:0]   dividend,
    input  logic [MAN_W:0]   divisor,
    output logic [MAN_W+1:0] quot
);
    localparam int QW = MAN_W + 2;

    logic [MAN_W:0]  rem   [QW+1];
    logic [QW-1:0]   lowbits;

    // Remainder entering the first row: the dividend less its last bit.
    assign rem[0]  = {1'b0, dividend[MAN_W:1]};
    // Bits brought down, one per row, most significant first.
    assign lowbits = {dividend[0], {(QW-1){1'b0}}};

    for (genvar r = 0; r < QW; r++) begin : g_row
        fpdiv_pu_row #(.MAN_W(MAN_W)) u_row (
            .rem_in  (rem[r]),
            .dbit    (lowbits[QW-1-r]),
            .divisor (divisor),
            .qbit    (quot[QW-1-r]),
            .rem_out (rem[r+1])
        );
    end
endmodule

// File: rtl/fpdiv_exp_unit.sv
module fpdiv_exp_unit
    import fpdiv_pkg::*;
(
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             norm_hi,
    output logic [EXP_W-1:0] exp_res,
    output logic             under,
    output logic             over
);
    localparam int EW = EXP_W + 2;
    localparam logic [EW-1:0] BIAS_V = EW'(BIAS);
    localparam logic [EW-2:0] MAX_V  = (EW-1)'(EXP_MAX);

    logic [EW-1:0] e_full;

    always_comb begin
        // Difference, bias put back, and one taken off when the quotient is below 1.0.
        e_full  = {2'b00, exp_a} - {2'b00, exp_b} + BIAS_V - {{(EW-1){1'b0}}, ~norm_hi};
        under   = e_full[EW-1] | (e_full == '0);
        over    = ~e_full[EW-1] & (e_full[EW-2:0] >= MAX_V);
        exp_res = e_full[EXP_W-1:0];
    end
endmodule

// File: rtl/fpdiv_sa_top.sv
module fpdiv_sa_top
    import fpdiv_pkg::*;
#(
    parameter int MAN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MAN_W+8:0] in_a,
    input  logic [MAN_W+8:0] in_b,
    output logic             out_valid,
    output logic [MAN_W+8:0] out_q
);
    localparam int W  = 1 + EXP_W + MAN_W;
    localparam int QW = MAN_W + 2;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] q;
    } state_t;

    state_t state_d, state_q;

    logic [EXP_W-1:0] ea, eb, exp_res;
    logic [MAN_W:0]   ma, mb;
    logic [QW-1:0]    qm;
    logic             sgn, under, over;

    assign ea  = in_a[W-2:MAN_W];
    assign eb  = in_b[W-2:MAN_W];
    assign ma  = {1'b1, in_a[MAN_W-1:0]};
    assign mb  = {1'b1, in_b[MAN_W-1:0]};
    assign sgn = in_a[W-1] ^ in_b[W-1];

    fpdiv_mant_array #(.MAN_W(MAN_W)) u_arr (
        .dividend (ma),
        .divisor  (mb),
        .quot     (qm)
    );

    fpdiv_exp_unit u_exp (
        .exp_a   (ea),
        .exp_b   (eb),
        .norm_hi (qm[QW-1]),
        .exp_res (exp_res),
        .under   (under),
        .over    (over)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            if (eb == '0) begin
                state_d.q = {sgn, EXP_W'(EXP_MAX), {MAN_W{1'b0}}};
            end else if (ea == '0 || under) begin
                state_d.q = {sgn, {(W-1){1'b0}}};
            end else if (over) begin
                state_d.q = {sgn, EXP_W'(EXP_MAX), {MAN_W{1'b0}}};
            end else if (qm[QW-1]) begin
                state_d.q = {sgn, exp_res, qm[MAN_W:1]};
            end else begin
                state_d.q = {sgn, exp_res, qm[MAN_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_q     = state_q.q;
endmodule

// File: rtl/fpdiv_sa_chk.sv
module fpdiv_sa_chk #(
    parameter int MAN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [MAN_W+8:0] in_a,
    input logic [MAN_W+8:0] in_b,
    input logic             out_valid,
    input logic [MAN_W+8:0] out_q
);
    localparam int W = MAN_W + 9;

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_q[W-1] == ($past(in_a[W-1]) ^ $past(in_b[W-1])));
    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_q));
    // R8
    a_r8_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_b[W-2:MAN_W] == '0) |=>
        (out_q[W-2:MAN_W] == '1 && out_q[MAN_W-1:0] == '0));
    // R7
    a_r7_zero_dividend: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[W-2:MAN_W] == '0 && in_b[W-2:MAN_W] != '0) |=>
        out_q[W-2:0] == '0);
    // R9
    a_r9_self_divide: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a == in_b && in_a[W-2:MAN_W] != '0) |=>
        out_q[W-2:0] == {8'd127, {MAN_W{1'b0}}});
endmodule

bind fpdiv_sa_top fpdiv_sa_chk #(.MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_q     (out_q)
);

// File: tb/fpdiv_sa_top_tb.sv
module fpdiv_sa_top_tb;
    localparam int M = 7;
    localparam int W = M + 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_q = '0;
    string        exp_tag = "R2";

    always #10 clk = ~clk;

    fpdiv_sa_top #(.MAN_W(M)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_q(out_q)
    );

    function automatic logic [W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                            output string tag);
        logic s;
        int ea, eb, ma, mb, e, m;
        s  = a[W-1] ^ b[W-1];
        ea = int'(a[W-2:M]);
        eb = int'(b[W-2:M]);
        if (eb == 0) begin tag = "R8"; return {s, 8'hFF, {M{1'b0}}}; end
        if (ea == 0) begin tag = "R7"; return {s, {(W-1){1'b0}}}; end
        ma = (1 << M) + int'(a[M-1:0]);
        mb = (1 << M) + int'(b[M-1:0]);
        if (ma >= mb) begin e = ea - eb + 127; m = (ma << M) / mb; end
        else          begin e = ea - eb + 126; m = (ma << (M+1)) / mb; end
        if (e <= 0)   begin tag = "R5"; return {s, {(W-1){1'b0}}}; end
        if (e >= 255) begin tag = "R6"; return {s, 8'hFF, {M{1'b0}}}; end
        tag = (a == b) ? "R9" : "R3 R4";
        return {s, 8'(e), M'(m - (1 << M))};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Checks the outputs from the previous drive, then drives a new pair.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        string t;
        logic [W-1:0] r;
        @(negedge clk);
        check("R2 valid", W'(out_valid), W'(exp_valid));
        if (exp_valid) begin
            check("R1 sign", W'(out_q[W-1]), W'(exp_q[W-1]));
            check(exp_tag, out_q, exp_q);
        end else begin
            check("R10 hold", out_q, exp_q);
        end
        in_valid = v; in_a = a; in_b = b;
        r = ref_div(a, b, t);
        exp_valid = v;
        if (v) begin exp_q = r; exp_tag = t; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state (R2)
        check("R2 reset valid", W'(out_valid), '0);
        check("R2 reset q", out_q, '0);
        rst_n = 1'b1;
        step(1, 16'h4040, 16'h4000);  // 3/2, R3 R4
        step(1, 16'h3F80, 16'h4040);  // 1/3, below-one branch
        step(1, 16'hBF80, 16'h4000);  // negative, R1
        step(1, 16'h3FC0, 16'h3FC0);  // R9
        step(0, 16'h1234, 16'h5678);  // R10 junk while idle
        step(0, 16'hFFFF, 16'h0001);
        step(1, 16'h7F00, 16'h0080);  // R6 overflow
        step(1, 16'h0080, 16'h7F00);  // R5 underflow
        step(1, 16'h0080, 16'h3F80);  // exponent exactly 1: R4 boundary
        step(1, 16'h0080, 16'h3FC0);  // drops to 0: R5 boundary
        step(1, 16'h7F00, 16'h3F00);  // exponent 254+... overflow edge R6
        step(1, 16'h8000, 16'h3F80);  // R7 negative zero dividend
        step(1, 16'h3F80, 16'h8000);  // R8
        step(1, 16'h0000, 16'h0000);  // R8 over R7
        step(1, 16'hFF7F, 16'hFF7F);  // R9 at top exponent
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] a, b;
            logic v;
            a = W'($urandom);
            b = W'($urandom);
            if ((i % 5) == 0) b = a;
            v = ($urandom_range(0, 5) != 0);
            step(v, a, b);
        end
        step(0, '0, '0);
        step(0, '0, '0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule